// File: doc/BRIEF.md
# Low-Power Clock Sequencer

This block decides where the system clock comes from and which clocks are gated while the chip moves between normal running and three retention states. In the light sleep state only the processor clock stops; peripheral and memory-controller clocks keep running, and any interrupt resumes execution. Two deeper retention states sit beside it. The slow-clock retention state moves the system clock onto the slow oscillator and stops the main oscillator. The deepest state gates every clock, parks the master clock selection on the fast RC oscillator, and resumes only on wake sources that software has enabled.

Software enters the light sleep state by writing the processor-clock-off command and then executing wait-for-interrupt. The same two steps with the deep-select input high lead to the slow-clock retention state. The deepest state is entered by a one-shot wait-mode command, or by holding the low-power select input while the processor issues wait-for-event. Before a retention state is committed there is a short entry window, and a wake during it cancels the entry. Every change of clock source is made with the system clock gated on both sides of the change. The master-clock-ready flag drops once the clocks are gated and rises again only after the main oscillator reports ready on the way back. A peripheral clock status register, set and cleared through write strobes, can be read back to restore the gating after wake.

Top module: `lp_clk_seq`

## Requirements
- R1: After reset the block is running: core_clk_en=1, sys_clk_en=1, clk_src=0 (main), mck_rdy=1, main_osc_en=1, lp_mode=0, and per_stat is all ones when PER_RST_ON=1.
- R2: A core_off_wr pulse followed later by a wfi pulse with deep_sel=0 enters light sleep one cycle after the wfi edge: core_clk_en=0, lp_mode=1, while sys_clk_en, per_clk_en and mck_rdy are unchanged.
- R3: A wfi pulse with no core_off_wr since the last accepted entry is ignored. In light sleep, irq_any returns the block to running (lp_mode=0, core_clk_en=1) one cycle later.
- R4: With deep_sel=1 the same command pair enters slow-clock retention (lp_mode=2). Outputs then step through ENTRY_CYC entry cycles (core off, mck_rdy=1, clk_src=0), one gate cycle (sys_clk_en=0, mck_rdy=0, clk_src=0) and one switch cycle (clk_src=1, sys_clk_en=0), and reach sleep with clk_src=1, sys_clk_en=1, main_osc_en=0, mck_rdy=0.
- R5: In slow-clock retention, irq_any starts the exit. The next cycle gates (sys_clk_en=0, clk_src still 1), the one after switches to clk_src=0, and the block then waits with mck_rdy=0 until main_rdy is high before it returns to running.
- R6: The deepest state (lp_mode=3) is entered by a wait_mode_set pulse, or by a wfe pulse while lpm_sel=1. A wfe pulse with lpm_sel=0 is ignored. The entry timing matches R4, with clk_src=2 (fast RC). In sleep sys_clk_en=0, per_clk_en=0 and mck_rdy=0.
- R7: In the deepest state only a bit set in both wake_src and wake_en wakes the block. irq_any and sources that are not enabled leave it asleep. The exit timing matches R5.
- R8: The wake condition of the target state (irq_any for slow-clock retention, enabled wake_src for the deepest state), seen during the entry window, returns the block to running on the next cycle, and mck_rdy stays high throughout.
- R9: clk_src changes only when sys_clk_en is 0 both in the cycle before the change and in the cycle of the change.
- R10: per_en_wr sets the per_stat bits selected by per_wdata and per_dis_wr clears them; when both strobes hit the same bit in one cycle, clear wins. Writing all ones with per_dis_wr gates every peripheral clock. per_clk_en equals per_stat while sys_clk_en=1 and is 0 otherwise.
- R11: mck_rdy falls only in a cycle with sys_clk_en=0, and it is high whenever the block is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_off_wr | input | 1 | Processor-clock-off command strobe |
| deep_sel | input | 1 | Selects slow-clock retention instead of light sleep on wfi |
| wfi | input | 1 | Wait-for-interrupt handshake pulse |
| wfe | input | 1 | Wait-for-event handshake pulse |
| wait_mode_set | input | 1 | One-shot command for the deepest state |
| lpm_sel | input | 1 | Routes wfe into the deepest state |
| irq_any | input | 1 | Any enabled interrupt pending |
| wake_src | input | NW | Wake event lines usable in the deepest state |
| wake_en | input | NW | Enable mask for wake_src |
| main_rdy | input | 1 | Main oscillator and PLL ready |
| per_en_wr | input | 1 | Peripheral clock enable strobe |
| per_dis_wr | input | 1 | Peripheral clock disable strobe |
| per_wdata | input | NPER | Peripheral select mask for the strobes |
| core_clk_en | output | 1 | Processor clock gate |
| sys_clk_en | output | 1 | System clock gate |
| clk_src | output | 2 | Source select: 0 main, 1 slow, 2 fast RC |
| main_osc_en | output | 1 | Main oscillator enable |
| mck_rdy | output | 1 | Master clock ready flag |
| lp_mode | output | 2 | 0 run, 1 light sleep, 2 slow retention, 3 deepest |
| per_clk_en | output | NPER | Peripheral clock gates |
| per_stat | output | NPER | Peripheral clock status |

## Verification
The assertions assume single-cycle pulses on the command and handshake inputs. They also assume that wake inputs are synchronous with clk when SYNC_STAGES is 0, and that main_rdy only matters in the wait state after a wake. The stimulus drives every input on the falling edge. Commands are issued only from the running state, except wake events, which are held for exactly one cycle. Random peripheral writes run while the block is running, and random sleep and wake visits come in only through the light sleep path, so the expected outputs follow from the requirement tables alone.

// File: rtl/lpcs_pkg.sv
`timescale 1ns/1ps
package lpcs_pkg;

   typedef enum logic [3:0] {
      S_RUN, S_IDLE, S_ENTER, S_GATE, S_SWITCH,
      S_SLEEP, S_WGATE, S_WSW, S_WRDY
   } seq_st_t;

   typedef enum logic [1:0] {
      M_RUN  = 2'd0,
      M_IDLE = 2'd1,
      M_SLOW = 2'd2,
      M_DEEP = 2'd3
   } lp_mode_t;

   typedef enum logic [1:0] {
      SRC_MAIN = 2'd0,
      SRC_SLOW = 2'd1,
      SRC_RC   = 2'd2
   } clk_src_t;

   function automatic clk_src_t src_of(lp_mode_t m);
      case (m)
         M_SLOW:  return SRC_SLOW;
         M_DEEP:  return SRC_RC;
         default: return SRC_MAIN;
      endcase
   endfunction

endpackage

// File: rtl/lpcs_wake.sv
`timescale 1ns/1ps
module lpcs_wake #(
   parameter int NW          = 4,
   parameter int SYNC_STAGES = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          irq_any,
   input  logic [NW-1:0] wake_src,
   input  logic [NW-1:0] wake_en,
   output logic          irq_o,
   output logic          fwake_o
);

   logic [1:0] raw;
   assign raw = {irq_any, |(wake_src & wake_en)};

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign irq_o   = raw[1];
         assign fwake_o = raw[0];
      end else begin : g_sync
         logic [1:0] chain [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) chain[i] <= '0;
            end else begin
               chain[0] <= raw;
               for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
            end
         end
         assign irq_o   = chain[SYNC_STAGES-1][1];
         assign fwake_o = chain[SYNC_STAGES-1][0];
      end
   endgenerate

endmodule

// File: rtl/lpcs_perclk.sv
`timescale 1ns/1ps
module lpcs_perclk #(
   parameter int NPER      = 8,
   parameter bit PER_RST_ON = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en_wr,
   input  logic            dis_wr,
   input  logic [NPER-1:0] wdata,
   input  logic            sys_en,
   output logic [NPER-1:0] stat,
   output logic [NPER-1:0] gate
);

   localparam logic [NPER-1:0] RST_VAL = PER_RST_ON ? '1 : '0;

   logic [NPER-1:0] set_m, clr_m;
   assign set_m = en_wr  ? wdata : '0;
   assign clr_m = dis_wr ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat <= RST_VAL;
      else        stat <= (stat | set_m) & ~clr_m;
   end

   assign gate = stat & {NPER{sys_en}};

   assert_all_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (dis_wr && (&wdata)) |=> (stat == '0));

   assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (en_wr && dis_wr) |=> ((stat & $past(wdata)) == '0));

endmodule

// File: rtl/lpcs_ctrl.sv
`timescale 1ns/1ps
module lpcs_ctrl
   import lpcs_pkg::*;
#(
   parameter int ENTRY_CYC = 4
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     core_off_wr,
   input  logic     deep_sel,
   input  logic     wfi,
   input  logic     wfe,
   input  logic     wait_mode_set,
   input  logic     lpm_sel,
   input  logic     irq_i,
   input  logic     fwake_i,
   input  logic     main_rdy,
   output logic     core_en_o,
   output logic     sys_en_o,
   output clk_src_t src_o,
   output logic     main_osc_en_o,
   output logic     mck_rdy_o,
   output lp_mode_t mode_o
);

   localparam int CW = (ENTRY_CYC < 2) ? 1 : $clog2(ENTRY_CYC);
   localparam logic [CW-1:0] LAST = CW'(ENTRY_CYC - 1);

   seq_st_t        st;
   lp_mode_t       tgt;
   logic [CW-1:0]  cnt;
   logic           off_flag;
   logic           wake_now;

   assign wake_now = (tgt == M_DEEP) ? fwake_i : irq_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_RUN;
         tgt      <= M_RUN;
         cnt      <= '0;
         off_flag <= 1'b0;
      end else begin
         if (core_off_wr) off_flag <= 1'b1;
         case (st)
            S_RUN: begin
               if (wait_mode_set || (lpm_sel && wfe)) begin
                  st       <= S_ENTER;
                  tgt      <= M_DEEP;
                  cnt      <= '0;
                  off_flag <= 1'b0;
               end else if (wfi && off_flag) begin
                  off_flag <= 1'b0;
                  cnt      <= '0;
                  st       <= deep_sel ? S_ENTER : S_IDLE;
                  tgt      <= deep_sel ? M_SLOW  : M_IDLE;
               end
            end
            S_IDLE: if (irq_i) begin
               st  <= S_RUN;
               tgt <= M_RUN;
            end
            S_ENTER: begin
               if (wake_now) begin
                  st  <= S_RUN;
                  tgt <= M_RUN;
               end else if (cnt == LAST) begin
                  st <= S_GATE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            S_GATE:   st <= S_SWITCH;
            S_SWITCH: st <= S_SLEEP;
            S_SLEEP:  if (wake_now) st <= S_WGATE;
            S_WGATE:  st <= S_WSW;
            S_WSW:    st <= S_WRDY;
            S_WRDY: if (main_rdy) begin
               st  <= S_RUN;
               tgt <= M_RUN;
            end
            default: begin
               st  <= S_RUN;
               tgt <= M_RUN;
            end
         endcase
      end
   end

   always_comb begin
      core_en_o     = (st == S_RUN);
      mck_rdy_o     = (st == S_RUN) || (st == S_IDLE) || (st == S_ENTER);
      main_osc_en_o = !((st == S_SWITCH) || (st == S_SLEEP));
      mode_o        = tgt;
      case (st)
         S_SWITCH, S_SLEEP, S_WGATE: src_o = src_of(tgt);
         default:                    src_o = SRC_MAIN;
      endcase
      case (st)
         S_RUN, S_IDLE, S_ENTER: sys_en_o = 1'b1;
         S_SLEEP:                sys_en_o = (tgt == M_SLOW);
         default:                sys_en_o = 1'b0;
      endcase
   end

   assert_src_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(src_o) |-> (!sys_en_o && !$past(sys_en_o)));

   assert_abort_keeps_rdy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_ENTER && wake_now) |=> (core_en_o && mck_rdy_o));

   assert_deep_filters_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_SLEEP && tgt == M_DEEP && !fwake_i) |=> (src_o == SRC_RC && !sys_en_o));

   assert_mck_fall_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mck_rdy_o) |-> !sys_en_o);

   assert_ready_waits_osc_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_WRDY && !main_rdy) |=> !mck_rdy_o);

endmodule

// File: rtl/lp_clk_seq.sv
`timescale 1ns/1ps
module lp_clk_seq
   import lpcs_pkg::*;
#(
   parameter int NW          = 4,
   parameter int NPER        = 8,
   parameter int ENTRY_CYC   = 4,
   parameter int SYNC_STAGES = 0,
   parameter bit PER_RST_ON  = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            core_off_wr,
   input  logic            deep_sel,
   input  logic            wfi,
   input  logic            wfe,
   input  logic            wait_mode_set,
   input  logic            lpm_sel,
   input  logic            irq_any,
   input  logic [NW-1:0]   wake_src,
   input  logic [NW-1:0]   wake_en,
   input  logic            main_rdy,
   input  logic            per_en_wr,
   input  logic            per_dis_wr,
   input  logic [NPER-1:0] per_wdata,
   output logic            core_clk_en,
   output logic            sys_clk_en,
   output logic [1:0]      clk_src,
   output logic            main_osc_en,
   output logic            mck_rdy,
   output logic [1:0]      lp_mode,
   output logic [NPER-1:0] per_clk_en,
   output logic [NPER-1:0] per_stat
);

   generate
      if (NW < 1)          begin : g_bad_nw  $error("NW must be at least 1");          end
      if (NPER < 1)        begin : g_bad_np  $error("NPER must be at least 1");        end
      if (ENTRY_CYC < 1)   begin : g_bad_ec  $error("ENTRY_CYC must be at least 1");   end
      if (SYNC_STAGES < 0) begin : g_bad_ss  $error("SYNC_STAGES must not be negative"); end
   endgenerate

   logic     irq_s, fwake_s;
   clk_src_t src_e;
   lp_mode_t mode_e;

   lpcs_wake #(.NW(NW), .SYNC_STAGES(SYNC_STAGES)) u_wake (
      .clk(clk), .rst_n(rst_n), .irq_any(irq_any),
      .wake_src(wake_src), .wake_en(wake_en),
      .irq_o(irq_s), .fwake_o(fwake_s)
   );

   lpcs_ctrl #(.ENTRY_CYC(ENTRY_CYC)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .core_off_wr(core_off_wr), .deep_sel(deep_sel),
      .wfi(wfi), .wfe(wfe), .wait_mode_set(wait_mode_set), .lpm_sel(lpm_sel),
      .irq_i(irq_s), .fwake_i(fwake_s), .main_rdy(main_rdy),
      .core_en_o(core_clk_en), .sys_en_o(sys_clk_en), .src_o(src_e),
      .main_osc_en_o(main_osc_en), .mck_rdy_o(mck_rdy), .mode_o(mode_e)
   );

   lpcs_perclk #(.NPER(NPER), .PER_RST_ON(PER_RST_ON)) u_per (
      .clk(clk), .rst_n(rst_n), .en_wr(per_en_wr), .dis_wr(per_dis_wr),
      .wdata(per_wdata), .sys_en(sys_clk_en), .stat(per_stat), .gate(per_clk_en)
   );

   assign clk_src = src_e;
   assign lp_mode = mode_e;

   assert_per_follow_sys_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (|per_clk_en) |-> sys_clk_en);

   assert_deep_all_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_mode == 2'd3 && !mck_rdy && clk_src == 2'd2) |-> (!sys_clk_en && per_clk_en == '0));

   assert_run_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
      core_clk_en |-> (mck_rdy && sys_clk_en));

endmodule

// File: tb/tb_lp_clk_seq.sv
`timescale 1ns/1ps
module tb_lp_clk_seq;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic core_off_wr = 0, deep_sel = 0, wfi = 0, wfe = 0, wait_mode_set = 0, lpm_sel = 0;
   logic irq_any = 0, main_rdy = 1;
   logic [3:0] wake_src = '0, wake_en = '0;
   logic per_en_wr = 0, per_dis_wr = 0;
   logic [7:0] per_wdata = '0;
   logic core_clk_en, sys_clk_en, main_osc_en, mck_rdy;
   logic [1:0] clk_src, lp_mode;
   logic [7:0] per_clk_en, per_stat;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [7:0] pm;

   always #4 clk = ~clk;

   lp_clk_seq dut (
      .clk(clk), .rst_n(rst_n), .core_off_wr(core_off_wr), .deep_sel(deep_sel),
      .wfi(wfi), .wfe(wfe), .wait_mode_set(wait_mode_set), .lpm_sel(lpm_sel),
      .irq_any(irq_any), .wake_src(wake_src), .wake_en(wake_en), .main_rdy(main_rdy),
      .per_en_wr(per_en_wr), .per_dis_wr(per_dis_wr), .per_wdata(per_wdata),
      .core_clk_en(core_clk_en), .sys_clk_en(sys_clk_en), .clk_src(clk_src),
      .main_osc_en(main_osc_en), .mck_rdy(mck_rdy), .lp_mode(lp_mode),
      .per_clk_en(per_clk_en), .per_stat(per_stat)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] per_model(logic [7:0] cur, logic en, logic dis, logic [7:0] d);
      logic [7:0] n;
      n = cur;
      if (en)  n = n | d;
      if (dis) n = n & ~d;
      return n;
   endfunction

   task automatic step();
      @(negedge clk);
   endtask

   // R9 monitor: source changes only with the system clock gated around it
   logic prev_sys = 1'b1;
   logic [1:0] prev_src = 2'd0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (clk_src !== prev_src)
            chk("R9 gated source change", {30'd0, prev_sys, sys_clk_en}, 32'd0);
      end
      prev_sys = sys_clk_en;
      prev_src = clk_src;
   end

   task automatic run_state(input string tag);
      chk({tag, " core on"}, core_clk_en, 1);
      chk({tag, " mode run"}, lp_mode, 0);
      chk({tag, " mck_rdy"}, mck_rdy, 1);
      chk({tag, " sys on"}, sys_clk_en, 1);
      chk({tag, " src main"}, clk_src, 0);
   endtask

   // entry walk: called on the first sample after the triggering edge
   task automatic walk_entry(input string tag, input logic [1:0] m, input logic [1:0] s, input logic sleep_sys);
      for (int i = 0; i < 4; i++) begin
         if (i > 0) step();
         chk({tag, " entry core off"}, core_clk_en, 0);
         chk({tag, " entry mck high"}, mck_rdy, 1);
         chk({tag, " entry mode"}, lp_mode, m);
      end
      step();
      chk({tag, " gate sys off"}, sys_clk_en, 0);
      chk({tag, " gate mck low"}, mck_rdy, 0);
      chk({tag, " gate src main"}, clk_src, 0);
      step();
      chk({tag, " switch src"}, clk_src, s);
      chk({tag, " switch sys off"}, sys_clk_en, 0);
      step();
      chk({tag, " sleep src"}, clk_src, s);
      chk({tag, " sleep sys"}, sys_clk_en, sleep_sys);
      chk({tag, " sleep osc off"}, main_osc_en, 0);
      chk({tag, " sleep mck low"}, mck_rdy, 0);
      chk({tag, " sleep per gate"}, per_clk_en, sleep_sys ? pm : 8'h00);
   endtask

   // exit walk with main_rdy high: called on the first sample after the wake edge
   task automatic walk_exit(input string tag, input logic [1:0] s);
      chk({tag, " wgate sys off"}, sys_clk_en, 0);
      chk({tag, " wgate src held"}, clk_src, s);
      step();
      chk({tag, " wswitch src main"}, clk_src, 0);
      step();
      chk({tag, " wait mck low"}, mck_rdy, 0);
      step();
      run_state({tag, " back"});
   endtask

   task automatic per_write(input logic en, input logic dis, input logic [7:0] d);
      per_en_wr = en; per_dis_wr = dis; per_wdata = d;
      step();
      per_en_wr = 0; per_dis_wr = 0;
      pm = per_model(pm, en, dis, d);
   endtask

   task automatic pulse_core_off();
      core_off_wr = 1; step(); core_off_wr = 0;
   endtask

   initial begin
      #800000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      pm = 8'hFF;
      repeat (3) step();
      rst_n = 1;
      step();
      // R1 reset state
      run_state("R1");
      chk("R1 osc on", main_osc_en, 1);
      chk("R1 per_stat reset", per_stat, 8'hFF);

      // R10 directed: all-ones disable, then set, then clear-wins
      per_write(1'b0, 1'b1, 8'hFF);
      chk("R10 all off stat", per_stat, 8'h00);
      chk("R10 all off gates", per_clk_en, 8'h00);
      per_write(1'b1, 1'b0, 8'hA5);
      chk("R10 enable set", per_stat, 8'hA5);
      per_write(1'b1, 1'b1, 8'h0F);
      chk("R10 clear wins", per_stat, pm);
      chk("R10 gates follow", per_clk_en, pm);

      // R10 random peripheral writes
      for (int i = 0; i < 60; i++) begin
         per_write(1'($urandom), 1'($urandom), 8'($urandom));
         chk("R10 random stat", per_stat, pm);
         chk("R10 random gate", per_clk_en, pm);
      end

      // R3 wfi without a prior core-off write is ignored
      wfi = 1; step(); wfi = 0;
      chk("R3 ignored wfi core", core_clk_en, 1);
      chk("R3 ignored wfi mode", lp_mode, 0);

      // R2 / R3 random light-sleep visits
      for (int k = 0; k < 8; k++) begin
         int dwell;
         dwell = 1 + int'($urandom % 5);
         pulse_core_off();
         wfi = 1; step(); wfi = 0;
         for (int j = 0; j < dwell; j++) begin
            chk("R2 idle core off", core_clk_en, 0);
            chk("R2 idle mode", lp_mode, 1);
            chk("R2 idle sys on", sys_clk_en, 1);
            chk("R2 idle per kept", per_clk_en, pm);
            chk("R2 idle mck", mck_rdy, 1);
            step();
         end
         irq_any = 1; step(); irq_any = 0;
         run_state("R3 idle exit");
      end

      // R4 / R5 slow-clock retention with delayed main_rdy
      deep_sel = 1;
      pulse_core_off();
      wfi = 1; step(); wfi = 0;
      walk_entry("R4", 2'd2, 2'd1, 1'b1);
      repeat (3) begin
         step();
         chk("R4 stays asleep", clk_src, 1);
      end
      main_rdy = 0;
      irq_any = 1; step(); irq_any = 0;
      chk("R5 wgate sys off", sys_clk_en, 0);
      chk("R5 wgate src held", clk_src, 1);
      step();
      chk("R5 wswitch src main", clk_src, 0);
      step();
      chk("R5 wait mck low", mck_rdy, 0);
      step();
      chk("R5 still waiting main_rdy", mck_rdy, 0);
      chk("R5 still waiting core", core_clk_en, 0);
      main_rdy = 1;
      step();
      run_state("R5 back");

      // R8 abort during slow entry
      pulse_core_off();
      wfi = 1; step(); wfi = 0;
      chk("R8 in entry", lp_mode, 2);
      step();
      chk("R8 entry mck", mck_rdy, 1);
      irq_any = 1; step(); irq_any = 0;
      run_state("R8 abort");
      deep_sel = 0;

      // R6 wfe without lpm_sel ignored
      wfe = 1; step(); wfe = 0;
      chk("R6 lone wfe ignored", lp_mode, 0);
      chk("R6 lone wfe core", core_clk_en, 1);

      // R6 entry via lpm_sel + wfe, R7 filtering
      wake_en = 4'b0001;
      lpm_sel = 1; wfe = 1; step(); wfe = 0; lpm_sel = 0;
      walk_entry("R6 wfe", 2'd3, 2'd2, 1'b0);
      irq_any = 1; step(); irq_any = 0;
      chk("R7 irq ignored src", clk_src, 2);
      chk("R7 irq ignored mck", mck_rdy, 0);
      wake_src = 4'b0110; step(); wake_src = '0;
      chk("R7 disabled source ignored", clk_src, 2);
      chk("R7 disabled source sys", sys_clk_en, 0);
      wake_src = 4'b0001; step(); wake_src = '0;
      walk_exit("R7", 2'd2);

      // R6 entry via wait-mode command, wake on another enabled line
      wake_en = 4'b1000;
      wait_mode_set = 1; step(); wait_mode_set = 0;
      walk_entry("R6 waitmode", 2'd3, 2'd2, 1'b0);
      wake_src = 4'b1000; step(); wake_src = '0;
      walk_exit("R7 line3", 2'd2);

      // R8 abort of deepest entry by an enabled wake line
      wait_mode_set = 1; step(); wait_mode_set = 0;
      chk("R8 deep entry mode", lp_mode, 3);
      wake_src = 4'b1000; step(); wake_src = '0;
      run_state("R8 deep abort");

      // R11 running after everything
      step();
      chk("R11 ready while running", mck_rdy, 1);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule